// File: doc/BRIEF.md
# PTE Run Coalescing Unit

After a TLB miss, the walker returns a whole cache line of eight page table entries that cover eight consecutive virtual pages. This unit scans that line once, at fill time, and folds neighbours into single translations wherever the virtual page and the physical page both step up by exactly one. Each result carries a base virtual page, a base physical page and a length, so one TLB slot can serve several pages. No alignment of the physical page is needed. The unit never starts a page walk of its own.

A run never leaves the group of four virtual pages that a set-associative TLB with its index taken two bits above the page offset maps to one set. Entries leave the unit on a valid/ready stream. The run that contains the page that missed goes first, so the stalled access can resume early. The unit takes the next line only after it has handed off every entry from the current one.

Top module: `pte_run_coalescer`

## Requirements
- R1: While reset is held and in the first cycle after it, `lineReady` is 1 and `entValid` is 0.
- R2: Two neighbouring valid PTEs in the same group share a run exactly when the physical page of the higher one equals the physical page of the lower one plus one, modulo 2^PPN_W.
- R3: A run never crosses a group boundary. A group is four VPNs whose index bits [1:0] run 0 to 3, so (entVpn mod 4) + entLenM1 never exceeds 3.
- R4: A PTE with its valid bit at 0 produces no entry and ends any run. A line with no valid PTE produces no entry, and `lineReady` returns 2 cycles after the line is accepted.
- R5: If the PTE at `missIdx` is valid, the run containing it is emitted first. All other runs follow in ascending VPN order.
- R6: `entLenM1` holds the run length minus one. A lone page gives 0 and a full four-page run gives 3. `entVpn` equals the line's base VPN (low three bits zero) plus the run's first slot, and `entPpn` is that slot's physical page.
- R7: `lineReady` is 0 from the cycle after a line is accepted until the handshake of its last entry. It is 1 in the cycle after that handshake, and `entValid` is then 0.
- R8: While `entValid` is 1 and `entReady` is 0, `entValid` stays 1 and the entry fields stay unchanged.
- R9: The line mapping VPN 0..5 to PPN 10, 11, 20, 21, 22, 23, with slots 6 and 7 invalid and the miss in slot 0, yields (0,10,len 2), (2,20,len 2), (4,22,len 2) in that order.
- R10: When the accepted line holds at least one valid PTE, `entValid` is 1 in the first cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineValid | input | 1 | A line of PTEs is offered |
| lineReady | output | 1 | The unit can accept a line |
| lineVpn | input | VPN_W | VPN of slot 0; multiple of eight |
| missIdx | input | 3 | Slot of the page that missed |
| pteValid | input | 8 | Valid bit per slot, bit i is slot i |
| ptePpn | input | 8*PPN_W | Physical page per slot, slot i in bits [i*PPN_W +: PPN_W] |
| entValid | output | 1 | A coalesced entry is offered |
| entReady | input | 1 | Consumer takes the entry |
| entVpn | output | VPN_W | First virtual page of the run |
| entPpn | output | PPN_W | First physical page of the run |
| entLenM1 | output | 2 | Run length minus one |

## Verification
The line is captured at the accepting edge. The first entry is on the outputs one cycle later, and every later entry appears on the edge that completes the previous handshake. An empty line frees the input one cycle later than a line with entries. The bench drives inputs on the falling edge and samples one time unit after it. It compares an entry only in a sample where valid and ready are both high, that is in the cycle before the edge that consumes it. After the last handshake it checks in the next sample that the stream has gone quiet and the input is open again. The sweep covers every valid mask, sixteen continuity patterns with a rotating miss slot, and pseudo-random backpressure.

// File: rtl/pte_coal_pkg.sv
package pte_coal_pkg;
  // Strobes sent from control to datapath
  typedef struct packed {
    logic load;  // capture the offered line
    logic pop;   // current entry handed off
  } ctlStrobes_t;
endpackage

// File: rtl/pte_coal_dp.sv
module pte_coal_dp
  import pte_coal_pkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 20,
  parameter int LINE_PTES  = 8,
  parameter int GROUP_PTES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   strobes,
  input  logic [VPN_W-1:0]              lineVpn,
  input  logic [$clog2(LINE_PTES)-1:0]  missIdx,
  input  logic [LINE_PTES-1:0]          pteValid,
  input  logic [LINE_PTES*PPN_W-1:0]    ptePpn,
  output logic                          anyPending,
  output logic                          lastPending,
  output logic [VPN_W-1:0]              entVpn,
  output logic [PPN_W-1:0]              entPpn,
  output logic [$clog2(GROUP_PTES)-1:0] entLenM1
);
  localparam int IDX_W = $clog2(LINE_PTES);
  localparam int LEN_W = $clog2(GROUP_PTES);

  logic [PPN_W-1:0]     inPpn [LINE_PTES];
  logic [LINE_PTES-1:0] inCont, inStart;
  logic [IDX_W-1:0]     inHead;

  logic [PPN_W-1:0]     ppnQ [LINE_PTES];
  logic [LINE_PTES-1:0] contQ, pendQ;
  logic [VPN_W-1:0]     baseQ;
  logic [IDX_W-1:0]     headQ;
  logic                 headFirstQ;

  logic [IDX_W-1:0]     lowIdx, selIdx;
  logic [LEN_W-1:0]     lenCnt;

  // Per-slot continuation and run-start detection on the incoming line
  for (genvar i = 0; i < LINE_PTES; i++) begin : g_slot
    assign inPpn[i] = ptePpn[i*PPN_W +: PPN_W];
    if (i % GROUP_PTES == 0) begin : g_edge
      assign inCont[i] = 1'b0;
    end else begin : g_inner
      assign inCont[i] = pteValid[i] && pteValid[i-1] &&
                         (inPpn[i] == inPpn[i-1] + PPN_W'(1));
    end
    assign inStart[i] = pteValid[i] && !inCont[i];
  end

  // Head of the run holding the missed slot: last start at or below it
  always_comb begin
    inHead = '0;
    for (int j = 0; j < LINE_PTES; j++) begin
      if (inStart[j] && (IDX_W'(j) <= missIdx)) inHead = IDX_W'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      contQ      <= '0;
      pendQ      <= '0;
      baseQ      <= '0;
      headQ      <= '0;
      headFirstQ <= 1'b0;
      for (int j = 0; j < LINE_PTES; j++) ppnQ[j] <= '0;
    end else if (strobes.load) begin
      contQ      <= inCont;
      pendQ      <= inStart;
      baseQ      <= lineVpn;
      headQ      <= inHead;
      headFirstQ <= pteValid[missIdx];
      for (int j = 0; j < LINE_PTES; j++) ppnQ[j] <= inPpn[j];
    end else if (strobes.pop) begin
      pendQ[selIdx] <= 1'b0;
      headFirstQ    <= 1'b0;
    end
  end

  // Lowest pending start
  always_comb begin
    lowIdx = '0;
    for (int j = LINE_PTES - 1; j >= 0; j--) begin
      if (pendQ[j]) lowIdx = IDX_W'(j);
    end
  end

  assign selIdx = headFirstQ ? headQ : lowIdx;

  // Length of the selected run: count continuation bits after its start
  always_comb begin
    logic             going;
    logic [IDX_W:0]   probe;
    lenCnt = '0;
    going  = 1'b1;
    for (int k = 1; k < GROUP_PTES; k++) begin
      probe = {1'b0, selIdx} + (IDX_W+1)'(k);
      if (going && (probe < (IDX_W+1)'(LINE_PTES)) && contQ[probe[IDX_W-1:0]])
        lenCnt = lenCnt + LEN_W'(1);
      else
        going = 1'b0;
    end
  end

  assign anyPending  = |pendQ;
  assign lastPending = anyPending && ((pendQ & (pendQ - LINE_PTES'(1))) == '0);
  assign entVpn      = baseQ + VPN_W'(selIdx);
  assign entPpn      = ppnQ[selIdx];
  assign entLenM1    = lenCnt;
endmodule

// File: rtl/pte_coal_ctl.sv
module pte_coal_ctl
  import pte_coal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineValid,
  input  logic        entReady,
  input  logic        anyPending,
  input  logic        lastPending,
  output logic        lineReady,
  output logic        entValid,
  output ctlStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_DRAIN} ctlState_t;
  ctlState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    lineReady    = 1'b0;
    entValid     = 1'b0;
    strobes.load = 1'b0;
    strobes.pop  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        lineReady    = 1'b1;
        strobes.load = lineValid;
        if (lineValid) stateNext = ST_DRAIN;
      end
      ST_DRAIN: begin
        entValid    = anyPending;
        strobes.pop = anyPending && entReady;
        if (!anyPending || (strobes.pop && lastPending)) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/pte_run_coalescer.sv
module pte_run_coalescer
  import pte_coal_pkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 20,
  parameter int LINE_PTES  = 8,
  parameter int GROUP_PTES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lineValid,
  output logic                          lineReady,
  input  logic [VPN_W-1:0]              lineVpn,
  input  logic [$clog2(LINE_PTES)-1:0]  missIdx,
  input  logic [LINE_PTES-1:0]          pteValid,
  input  logic [LINE_PTES*PPN_W-1:0]    ptePpn,
  output logic                          entValid,
  input  logic                          entReady,
  output logic [VPN_W-1:0]              entVpn,
  output logic [PPN_W-1:0]              entPpn,
  output logic [$clog2(GROUP_PTES)-1:0] entLenM1
);
  ctlStrobes_t strobes;
  logic        anyPending, lastPending;

  pte_coal_ctl u_ctl (
    .clk(clk), .rstN(rstN), .lineValid(lineValid), .entReady(entReady),
    .anyPending(anyPending), .lastPending(lastPending),
    .lineReady(lineReady), .entValid(entValid), .strobes(strobes)
  );

  pte_coal_dp #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .LINE_PTES(LINE_PTES), .GROUP_PTES(GROUP_PTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lineVpn(lineVpn),
    .missIdx(missIdx), .pteValid(pteValid), .ptePpn(ptePpn),
    .anyPending(anyPending), .lastPending(lastPending),
    .entVpn(entVpn), .entPpn(entPpn), .entLenM1(entLenM1)
  );
endmodule

// File: rtl/pte_run_coalescer_chk.sv
module pte_run_coalescer_chk #(
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 20,
  parameter int GROUP_PTES = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          lineValid,
  input logic                          lineReady,
  input logic                          entValid,
  input logic                          entReady,
  input logic [VPN_W-1:0]              entVpn,
  input logic [PPN_W-1:0]              entPpn,
  input logic [$clog2(GROUP_PTES)-1:0] entLenM1
);
  localparam int LEN_W = $clog2(GROUP_PTES);

  // R8: offered entry held under backpressure
  a_r8_hold_entry: assert property (@(posedge clk) disable iff (!rstN)
    entValid && !entReady |=> entValid && $stable(entVpn) && $stable(entPpn) && $stable(entLenM1));

  // R7: no new line while entries are outstanding
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    entValid |-> !lineReady);

  // R3: run stays inside its index group
  a_r3_in_group: assert property (@(posedge clk) disable iff (!rstN)
    entValid |-> (({1'b0, entVpn[LEN_W-1:0]} + {1'b0, entLenM1}) < (LEN_W+1)'(GROUP_PTES)));

  // R7: accepting a line closes the input for the next cycle
  a_r7_accept_closes: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && lineReady |=> !lineReady);
endmodule

bind pte_run_coalescer pte_run_coalescer_chk #(
  .VPN_W(VPN_W), .PPN_W(PPN_W), .GROUP_PTES(GROUP_PTES)
) u_chk (.*);

// File: tb/sim_pte_run_coalescer.sv
module sim_pte_run_coalescer;
  localparam int VW = 20, PW = 20, L = 8, G = 4;

  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;

  logic          lineValid = 1'b0, lineReady, entValid, entReady = 1'b0;
  logic [VW-1:0] lineVpn = '0, entVpn;
  logic [2:0]    missIdx = '0;
  logic [L-1:0]  pteValid = '0;
  logic [L*PW-1:0] ptePpn = '0;
  logic [PW-1:0] entPpn;
  logic [1:0]    entLenM1;

  pte_run_coalescer #(.VPN_W(VW), .PPN_W(PW), .LINE_PTES(L), .GROUP_PTES(G)) u0 (.*);

  int nChk = 0, nBad = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;
  int ppnA [L];
  bit vA [L];
  int expV [L], expP [L], expL [L];
  int nExp;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: starts, lengths, miss run first then ascending (R2 R3 R4 R5 R6)
  task automatic model(int baseVpn, int miss);
    bit st [L];
    int head;
    for (int i = 0; i < L; i++) begin
      bit cont;
      cont = (i % G != 0) && vA[i] && vA[i-1] && (ppnA[i] == ppnA[i-1] + 1);
      st[i] = vA[i] && !cont;
    end
    nExp = 0;
    head = -1;
    if (vA[miss]) for (int i = 0; i <= miss; i++) if (st[i]) head = i;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < L; i++) begin
        if (st[i] && ((pass == 0) ? (i == head) : (i != head))) begin
          int len;
          len = 1;
          for (int k = i + 1; k < L && (k % G != 0) && vA[k] && vA[k-1]
               && ppnA[k] == ppnA[k-1] + 1; k++) len++;
          expV[nExp] = baseVpn + i;
          expP[nExp] = ppnA[i];
          expL[nExp] = len - 1;
          nExp++;
        end
      end
    end
  endtask

  task automatic runLine(int baseVpn, int miss, string tag);
    int got, guard;
    bit held;
    logic [VW-1:0] hV; logic [PW-1:0] hP; logic [1:0] hL;
    model(baseVpn, miss);
    guard = 0;
    while (!lineReady && guard < 50) begin @(negedge clk); guard++; end
    lineValid = 1'b1;
    lineVpn   = VW'(baseVpn);
    missIdx   = 3'(miss);
    for (int i = 0; i < L; i++) begin
      pteValid[i] = vA[i];
      ptePpn[i*PW +: PW] = PW'(ppnA[i]);
    end
    @(negedge clk);
    lineValid = 1'b0;
    #1;
    chk(lineReady == 1'b0, "R7", {tag, " ready after accept"}, lineReady, 0);
    if (nExp > 0)
      chk(entValid == 1'b1, "R10", {tag, " first entry due"}, entValid, 1);
    got = 0; guard = 0; held = 0;
    while (got < nExp && guard < 200) begin
      entReady = lfsr[0] | lfsr[1];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (held)
        chk(entValid && entVpn == hV && entPpn == hP && entLenM1 == hL,
            "R8", {tag, " held entry vpn"}, entVpn, hV);
      held = 0;
      if (entValid && entReady) begin
        chk(entVpn == VW'(expV[got]), "R5", {tag, " vpn/order"}, entVpn, expV[got]);
        chk(entPpn == PW'(expP[got]), "R6", {tag, " ppn"}, entPpn, expP[got]);
        chk(entLenM1 == 2'(expL[got]), "R2", {tag, " lenM1"}, entLenM1, expL[got]);
        chk(lineReady == 1'b0, "R7", {tag, " ready while draining"}, lineReady, 0);
        got++;
      end else if (entValid) begin
        held = 1; hV = entVpn; hP = entPpn; hL = entLenM1;
      end
      @(negedge clk);
      guard++;
    end
    chk(got == nExp, "R4", {tag, " entry count"}, got, nExp);
    entReady = 1'b0;
    #1;
    if (nExp == 0) begin
      chk(entValid == 1'b0, "R4", {tag, " empty line gives no entry"}, entValid, 0);
      @(negedge clk);
      #1;
    end
    chk(entValid == 1'b0, "R7", {tag, " stream quiet after last"}, entValid, 0);
    chk(lineReady == 1'b1, "R7", {tag, " ready after last"}, lineReady, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(lineReady == 1'b1 && entValid == 1'b0, "R1", "in reset", {lineReady, entValid}, 2'b10);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(lineReady == 1'b1 && entValid == 1'b0, "R1", "after reset", {lineReady, entValid}, 2'b10);
    @(negedge clk);

    // R9 worked example
    begin
      int wp [6] = '{10, 11, 20, 21, 22, 23};
      for (int i = 0; i < L; i++) begin vA[i] = (i < 6); ppnA[i] = (i < 6) ? wp[i] : 0; end
      runLine(0, 0, "R9 example");
      chk(nExp == 3 && expL[0] == 1 && expP[1] == 20 && expV[2] == 4, "R9",
          "model list", nExp, 3);
    end

    // R3 fully contiguous line splits at the group edge, miss in upper group first (R5)
    for (int i = 0; i < L; i++) begin vA[i] = 1; ppnA[i] = 500 + i; end
    runLine(8'h40, 5, "R3 full line");

    // Sweep: every valid mask x 16 continuity patterns, rotating miss slot
    for (int vm = 0; vm < 256; vm++) begin
      for (int p = 0; p < 16; p++) begin
        logic [6:0] cm;
        cm = 7'(p * 37 + vm * 5);
        for (int i = 0; i < L; i++) begin
          vA[i] = vm[i];
          if (i == 0) ppnA[i] = 1000 + vm * 64 + p * 3;
          else ppnA[i] = ppnA[i-1] + (cm[i-1] ? 1 : 7);
        end
        runLine(((vm * 16 + p) * 8) & 20'hFFFF8, (vm + p) % 8, "sweep");
      end
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule